// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block holds the two threshold offsets that a FIFO flag generator compares against. The empty offset sets where the almost-empty flag trips. The full offset sets where the almost-full flag trips. Both offsets are driven straight out to the flag logic. The block does not contain the storage, the pointers or the comparison.

While master reset is held, the block loads a default value into both offsets and latches the programming mode. The default is chosen by two select pins together with the programming pin. The programming pin also picks the mode: high means serial, low means parallel. After reset, pulling the programming pin low gives access to the offsets. In parallel mode, offsets are written as words on the write bus. In serial mode, they are shifted in one bit per clock. In both modes they are read back as words on the read bus. Normal FIFO traffic is allowed only while the programming pin is high.

Top module: `fifo_thresh_loader`

## Requirements
- R1: While `rst_n` is low, each clock edge loads both offsets with the default for index `{prog_n, dflt_sel[1], dflt_sel[0]}`. That default is 2^(index+3)-1, limited to DEPTH-1. With DEPTH=1000 the eight values are 7, 15, 31, 63, 127, 255, 511 and 999. The same edge clears `rdata` to 0.
- R2: `serial_mode` takes the value of `prog_n` sampled during reset. It holds that value until the next reset.
- R3: In parallel mode, with `prog_n` low, each `wr_en` edge writes `wdata`. Writes alternate: the first after reset goes to the empty offset, the next to the full offset, and so on. The new value is visible after that edge.
- R4: With `prog_n` low, each `rd_en` edge places one offset on `rdata`, zero-extended. Reads alternate empty then full, starting with empty after reset. This works in either mode. `rdata` holds its value when no read happens.
- R5: In serial mode, with `prog_n` low, each `ser_en` edge shifts in one bit of `ser_din`. The stream is 2*W bits, LSB first: bits 0..W-1 form the empty offset and bits W..2W-1 form the full offset. Both offsets update together on the edge of the last bit. Before that edge they do not change.
- R6: Any written value above DEPTH-1 is stored as DEPTH-1, in either mode.
- R7: Offsets do not change while `prog_n` is high. Parallel writes have no effect in serial mode. Serial bits have no effect in parallel mode.
- R8: `fifo_access_en` is high only when `rst_n` is high and `prog_n` is high.
- R9: A master reset returns both write and read alternation to the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, sampled on clock |
| prog_n | input | 1 | Mode select during reset; low gives offset access afterwards |
| dflt_sel | input | 2 | Default offset select, sampled during reset |
| wr_en | input | 1 | Parallel offset write strobe |
| wdata | input | DATA_W | Parallel write data |
| rd_en | input | 1 | Offset readback strobe |
| rdata | output | DATA_W | Readback data |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial data bit |
| empty_ofs | output | $clog2(DEPTH) | Almost-empty offset to the flag generator |
| full_ofs | output | $clog2(DEPTH) | Almost-full offset to the flag generator |
| serial_mode | output | 1 | Programming mode latched at reset (1 = serial) |
| fifo_access_en | output | 1 | High when normal FIFO reads and writes may proceed |

## Verification
The bench targets the points where the write and read alternation could slip:
- Several write pairs are read back in order. A design that misses a toggle puts data into the wrong offset.
- An alternation is left half-finished across a reset. A design that keeps its toggle across reset writes the full offset first.

The serial path is checked one bit short of a full word. A design that commits early shows a changed offset at that point.

Values above the limit are written in both modes, including the default index whose value exceeds DEPTH-1. A missing clamp shows up as an offset past DEPTH-1.

Accesses in the wrong mode, and accesses with `prog_n` high, must leave both offsets unchanged.

// File: rtl/fifo_thresh_loader.sv
module fifo_thresh_loader #(
  parameter int DEPTH  = 1000,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prog_n,
  input  logic [1:0]                 dflt_sel,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rdata,
  input  logic                       ser_en,
  input  logic                       ser_din,
  output logic [$clog2(DEPTH)-1:0]   empty_ofs,
  output logic [$clog2(DEPTH)-1:0]   full_ofs,
  output logic                       serial_mode,
  output logic                       fifo_access_en
);
  localparam int W  = $clog2(DEPTH);
  localparam int SW = 2 * W;
  localparam int CW = $clog2(SW + 1);
  localparam int unsigned MAXV = DEPTH - 1;
  localparam logic [W-1:0]      MAXW = W'(MAXV);
  localparam logic [DATA_W-1:0] MAXD = DATA_W'(MAXV);

  function automatic logic [W-1:0] dflt(input logic [2:0] idx);
    int unsigned v;
    v = (32'd1 << (int'(idx) + 3)) - 32'd1;
    return (v > MAXV) ? MAXW : W'(v);
  endfunction

  function automatic logic [W-1:0] clip_w(input logic [W-1:0] v);
    return (v > MAXW) ? MAXW : v;
  endfunction

  logic          wr_sel, rd_sel;
  logic [SW-1:0] shreg;
  logic [CW-1:0] bit_cnt;

  wire prog     = rst_n && !prog_n;
  wire par_wr   = prog && !serial_mode && wr_en;
  wire par_rd   = prog && rd_en;
  wire ser_sh   = prog && serial_mode && ser_en;
  wire last_bit = ser_sh && (bit_cnt == CW'(SW - 1));
  wire [SW-1:0] sh_next = {ser_din, shreg[SW-1:1]};
  wire [W-1:0]  par_val = (wdata > MAXD) ? MAXW : wdata[W-1:0];

  assign fifo_access_en = rst_n && prog_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serial_mode <= prog_n;
      empty_ofs   <= dflt({prog_n, dflt_sel});
      full_ofs    <= dflt({prog_n, dflt_sel});
      wr_sel      <= 1'b0;
      rd_sel      <= 1'b0;
      shreg       <= '0;
      bit_cnt     <= '0;
      rdata       <= '0;
    end else begin
      if (par_wr) begin
        if (!wr_sel) empty_ofs <= par_val;
        else         full_ofs  <= par_val;
        wr_sel <= ~wr_sel;
      end
      if (ser_sh) begin
        shreg   <= sh_next;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) begin
          empty_ofs <= clip_w(sh_next[W-1:0]);
          full_ofs  <= clip_w(sh_next[SW-1:W]);
        end
      end
      if (par_rd) begin
        rdata  <= DATA_W'(rd_sel ? full_ofs : empty_ofs);
        rd_sel <= ~rd_sel;
      end
    end
  end

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_ofs <= MAXW) && (full_ofs <= MAXW));

  p_mode_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(serial_mode));

  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_n |=> $stable(empty_ofs) && $stable(full_ofs));

  p_par_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    serial_mode && !ser_en |=> $stable(empty_ofs) && $stable(full_ofs));

  p_partial_serial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sh && !last_bit |=> $stable(empty_ofs) && $stable(full_ofs));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !par_rd |=> $stable(rdata));

  p_access_r8: assert property (@(posedge clk)
    !rst_n |-> !fifo_access_en);
endmodule

// File: tb/fifo_thresh_loader_test.sv
module fifo_thresh_loader_test;
  localparam int DEPTH = 1000;
  localparam int DW    = 16;
  localparam int W     = 10;

  logic clk = 0, rst_n = 0, prog_n = 1, wr_en = 0, rd_en = 0, ser_en = 0, ser_din = 0;
  logic [1:0]    dflt_sel = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic [W-1:0]  empty_ofs, full_ofs;
  logic serial_mode, fifo_access_en;
  int checks = 0, fails = 0;

  fifo_thresh_loader #(.DEPTH(DEPTH), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .dflt_sel(dflt_sel),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
    .ser_en(ser_en), .ser_din(ser_din), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .serial_mode(serial_mode), .fifo_access_en(fifo_access_en));

  always #2 clk = ~clk;

  // {wdata, expected}; writes alternate empty/full
  localparam logic [31:0] PVEC [8] = '{
    {16'd5, 16'd5}, {16'd900, 16'd900},
    {16'd0, 16'd0}, {16'd999, 16'd999},
    {16'd1000, 16'd999}, {16'd65535, 16'd999},
    {16'd123, 16'd123}, {16'd1, 16'd1}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic pn);
    @(negedge clk);
    rst_n = 0; dflt_sel = sel; prog_n = pn;
    repeat (3) @(negedge clk);
    rst_n = 1; prog_n = 1;
  endtask

  task automatic pwrite(input logic [DW-1:0] v);
    prog_n = 0; wr_en = 1; wdata = v;
    @(negedge clk);
    wr_en = 0; prog_n = 1;
  endtask

  task automatic pread(output logic [DW-1:0] v);
    prog_n = 0; rd_en = 1;
    @(negedge clk);
    rd_en = 0; prog_n = 1;
    v = rdata;
  endtask

  task automatic sshift(input logic [2*W-1:0] word, input int nbits);
    prog_n = 0;
    for (int i = 0; i < nbits; i++) begin
      ser_en = 1; ser_din = word[i];
      @(negedge clk);
    end
    ser_en = 0; prog_n = 1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    @(negedge clk);
    rst_n = 0; dflt_sel = 2'b10; prog_n = 0;
    @(negedge clk); @(negedge clk);
    check("R8 access low in reset", fifo_access_en, 0);
    check("R1 default idx2 empty", empty_ofs, 31);
    check("R1 default idx2 full", full_ofs, 31);
    check("R1 rdata cleared", rdata, 0);
    rst_n = 1; prog_n = 1;
    @(negedge clk);
    check("R2 parallel mode", serial_mode, 0);
    check("R8 access high", fifo_access_en, 1);
    prog_n = 0; #1;
    check("R8 access low while programming", fifo_access_en, 0);
    prog_n = 1;

    for (int i = 0; i < 8; i += 2) begin
      pwrite(PVEC[i][31:16]);
      check("R3 empty written", empty_ofs, int'(PVEC[i][15:0]));
      pwrite(PVEC[i+1][31:16]);
      check("R3/R6 full written", full_ofs, int'(PVEC[i+1][15:0]));
      pread(rv); check("R4 read empty", rv, int'(PVEC[i][15:0]));
      pread(rv); check("R4 read full", rv, int'(PVEC[i+1][15:0]));
      @(negedge clk);
      check("R4 rdata holds", rdata, int'(PVEC[i+1][15:0]));
    end

    // R7: writes with prog_n high are ignored
    wr_en = 1; wdata = 16'd44; @(negedge clk); wr_en = 0;
    check("R7 locked empty", empty_ofs, 123);
    check("R7 locked full", full_ofs, 1);
    // R7: serial bits ignored in parallel mode
    sshift({10'd3, 10'd3}, 20);
    check("R7 serial ignored empty", empty_ofs, 123);
    check("R7 serial ignored full", full_ofs, 1);

    // R9: half-finished alternation, then reset
    pwrite(16'd77);
    do_reset(2'b00, 0);
    check("R1 default idx0", empty_ofs, 7);
    pwrite(16'd88);
    check("R9 write toggle restarted", empty_ofs, 88);
    check("R9 full untouched", full_ofs, 7);

    // Serial mode, idx7 -> clamped default
    do_reset(2'b11, 1);
    check("R2 serial mode", serial_mode, 1);
    check("R1/R6 default idx7 clamped", empty_ofs, 999);
    sshift({10'd45, 10'd300}, 19);
    check("R5 no early commit empty", empty_ofs, 999);
    check("R5 no early commit full", full_ofs, 999);
    sshift({10'd45, 10'd300} >> 19, 1);
    check("R5 serial empty", empty_ofs, 300);
    check("R5 serial full", full_ofs, 45);
    pwrite(16'd12);
    check("R7 parallel ignored in serial", empty_ofs, 300);
    pread(rv); check("R4 serial-mode read empty", rv, 300);
    pread(rv); check("R4 serial-mode read full", rv, 45);
    sshift({10'd0, 10'd1010}, 20);
    check("R6 serial clamp empty", empty_ofs, 999);
    check("R5 serial rewrite full", full_ofs, 0);
    do_reset(2'b01, 1);
    check("R1 default idx5", full_ofs, 255);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule